// File: doc/BRIEF.md
# Receive Gain-State Dwell Controller

This block picks between a full-gain and a reduced-gain setting for a radio receive front end. Two comparator flags arrive from outside: one says the measured signal strength sits at or above an upper trip level, the other says it sits below a lower release level. When neither flag is set, the level is inside the hysteresis band between the two levels (about 4 dB wide). A strong level sends the front end into reduced gain (a 36 dB cut) on the next clock edge. Reduced gain is held until the level has stayed below the release level, without a break, for a dwell of 2^K reference-clock cycles.

The dwell exists because on-off keyed data often has its high symbol above the trip level and its low symbol below the release level. Without a hold, the gain would flip on every bit. A 3-bit code selects K from a ladder of odd values. Code zero turns the function off and pins the front end at full gain. Every change of gain state raises a one-cycle pulse.

Top module: `agc_dwell_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `gain_reduce` is 0 and `gain_changed` is 0.
- R2: While `dwell_code` is 0, `gain_reduce` is 0 from the next clock edge onward, whatever the level flags show.
- R3: With `dwell_code` nonzero and `lvl_above` high at a clock edge, `gain_reduce` is 1 after that edge.
- R4: In reduced gain with a nonzero code, `gain_reduce` returns to 0 at exactly the 2^K-th consecutive edge at which `lvl_below` is high and `lvl_above` is low. After 2^K-1 such edges it is still 1.
- R5: A single edge with `lvl_above` high during the dwell restarts the count from zero.
- R6: An edge inside the hysteresis band (both flags low) also restarts the count from zero. While the level stays in the band, the current gain state is kept.
- R7: The value of K is taken from `dwell_code` at the first edge of a dwell run. A code change to another nonzero value during the run does not alter that run's length.
- R8: A change of `dwell_code` to 0 while in reduced gain drives `gain_reduce` to 0 at the next edge, with a `gain_changed` pulse.
- R9: `gain_changed` is 1 for exactly the cycles in which `gain_reduce` differs from its value in the previous cycle.
- R10: K = K_MIN + K_STEP*(code-1) for codes 1 to 7. With the defaults K_MIN=11 and K_STEP=2, codes 1 to 7 give K = 11, 13, 15, 17, 19, 21, 23.
- R11: In full gain, `lvl_below` has no effect: `gain_reduce` stays 0 and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_above | input | 1 | Level at or above the upper trip threshold |
| lvl_below | input | 1 | Level below the lower release threshold |
| dwell_code | input | 3 | 0 = function off; 1..7 select the dwell exponent K |
| gain_reduce | output | 1 | 1 = front end in reduced gain |
| gain_changed | output | 1 | One-cycle pulse on each gain-state change |

## Verification
A wrong dwell count shows up as the release edge of `gain_reduce` arriving one or more cycles early or late. It is visible at the edge where the run length reaches 2^K. A count that is not cleared by an above-band or in-band sample shows up as a release too soon after the interruption. A wrong latched K shows up only at the end of the run in which the code changed. Because of this, the bench compares both outputs against a behavioural model on every cycle, and it also checks exact release edges for each code.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic {
        GAIN_HIGH = 1'b0,
        GAIN_LOW  = 1'b1
    } gain_e;

    // Dwell exponent for a nonzero code: base plus a fixed step per code.
    function automatic int unsigned dwell_exp(input logic [2:0] code,
                                              input int unsigned k_min,
                                              input int unsigned k_step);
        int unsigned idx;
        idx = (code == 3'd0) ? 0 : (int'(code) - 1);
        return k_min + k_step * idx;
    endfunction

endpackage

// File: rtl/agc_code_decode.sv
module agc_code_decode
    import agc_pkg::*;
#(
    parameter int unsigned K_MIN  = 11,
    parameter int unsigned K_STEP = 2,
    parameter int unsigned KW     = $clog2(K_MIN + 6 * K_STEP + 1)
) (
    input  logic [2:0]    dwell_code,
    output logic          agc_on,
    output logic [KW-1:0] k_live
);

    logic [KW-1:0] k_table [8];

    for (genvar c = 0; c < 8; c++) begin : g_ktab
        if (c == 0) begin : g_off
            assign k_table[c] = '0;
        end else begin : g_on
            assign k_table[c] = KW'(dwell_exp(3'(c), K_MIN, K_STEP));
        end
    end

    always_comb begin
        agc_on = (dwell_code != 3'd0);
        k_live = k_table[dwell_code];
    end

endmodule

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer #(
    parameter int unsigned K_MIN  = 11,
    parameter int unsigned K_STEP = 2,
    parameter int unsigned KW     = $clog2(K_MIN + 6 * K_STEP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic [KW-1:0] k_live,
    output logic          expire
);

    localparam int unsigned K_MAX = K_MIN + 6 * K_STEP;
    localparam int unsigned CW    = K_MAX;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [KW-1:0] k_lat;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [KW-1:0] k_act;
    logic [CW-1:0] last_val;

    always_comb begin
        tmr_d    = tmr_q;
        // First sample of a run uses the live code; later samples the latched one.
        k_act    = (tmr_q.cnt == '0) ? k_live : tmr_q.k_lat;
        last_val = ~({CW{1'b1}} << k_act);
        expire   = count_en && (tmr_q.cnt == last_val);
        if (count_en && (tmr_q.cnt == '0)) begin
            tmr_d.k_lat = k_live;
        end
        if (!count_en || expire) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5 / R6: any break in the below-threshold run leaves the count at zero.
    p_break_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (tmr_q.cnt == '0));

    // R4: a running count never passes the last value of its latched exponent.
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != '0) |-> (tmr_q.cnt <= ~({CW{1'b1}} << tmr_q.k_lat)));

endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
    import agc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic agc_on,
    input  logic lvl_above,
    input  logic lvl_below,
    input  logic expire,
    output logic count_en,
    output logic gain_reduce,
    output logic gain_changed
);

    typedef struct packed {
        gain_e gain;
        logic  changed;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        count_en = agc_on && (fsm_q.gain == GAIN_LOW) && lvl_below && !lvl_above;
        if (!agc_on) begin
            fsm_d.gain = GAIN_HIGH;
        end else if (fsm_q.gain == GAIN_HIGH) begin
            if (lvl_above) begin
                fsm_d.gain = GAIN_LOW;
            end
        end else if (expire) begin
            fsm_d.gain = GAIN_HIGH;
        end
        fsm_d.changed = (fsm_d.gain != fsm_q.gain);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{gain: GAIN_HIGH, changed: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign gain_reduce  = (fsm_q.gain == GAIN_LOW);
    assign gain_changed = fsm_q.changed;

    p_off_forces_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !agc_on |=> !gain_reduce);

    p_trip_on_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_on && lvl_above) |=> gain_reduce);

    p_release_needs_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_reduce && agc_on && !lvl_below) |=> gain_reduce);

    p_pulse_marks_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gain_changed |-> (gain_reduce != $past(gain_reduce)));

    p_change_has_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_reduce != $past(gain_reduce)) |-> gain_changed);

endmodule

// File: rtl/agc_dwell_ctrl.sv
module agc_dwell_ctrl
    import agc_pkg::*;
#(
    parameter int unsigned K_MIN  = 11,
    parameter int unsigned K_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_above,
    input  logic       lvl_below,
    input  logic [2:0] dwell_code,
    output logic       gain_reduce,
    output logic       gain_changed
);

    localparam int unsigned KW = $clog2(K_MIN + 6 * K_STEP + 1);

    logic          agc_on;
    logic [KW-1:0] k_live;
    logic          count_en;
    logic          expire;

    agc_code_decode #(.K_MIN(K_MIN), .K_STEP(K_STEP), .KW(KW)) u_decode (
        .dwell_code (dwell_code),
        .agc_on     (agc_on),
        .k_live     (k_live)
    );

    agc_dwell_timer #(.K_MIN(K_MIN), .K_STEP(K_STEP), .KW(KW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .k_live   (k_live),
        .expire   (expire)
    );

    agc_gain_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .agc_on       (agc_on),
        .lvl_above    (lvl_above),
        .lvl_below    (lvl_below),
        .expire       (expire),
        .count_en     (count_en),
        .gain_reduce  (gain_reduce),
        .gain_changed (gain_changed)
    );

    // R11: in full gain a below-only level never trips the front end.
    p_below_ignored_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_reduce && !lvl_above) |=> !gain_reduce);

endmodule

// File: tb/agc_dwell_ctrl_tb_top.sv
module agc_dwell_ctrl_tb_top;

    localparam int KMIN  = 3;
    localparam int KSTEP = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl_above = 1'b0;
    logic       lvl_below = 1'b0;
    logic [2:0] dwell_code = 3'd0;
    logic       gain_reduce;
    logic       gain_changed;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    agc_dwell_ctrl #(.K_MIN(KMIN), .K_STEP(KSTEP)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_above    (lvl_above),
        .lvl_below    (lvl_below),
        .dwell_code   (dwell_code),
        .gain_reduce  (gain_reduce),
        .gain_changed (gain_changed)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Behavioural reference model.
    int m_gain = 0;
    int m_run  = 0;
    int m_k    = 0;
    int m_chg  = 0;

    always @(posedge clk) begin
        int prev;
        prev = m_gain;
        if (!rst_n) begin
            m_gain = 0; m_run = 0; m_k = 0;
        end else if (dwell_code == 0) begin
            m_gain = 0; m_run = 0;
        end else if (m_gain == 0) begin
            if (lvl_above) m_gain = 1;
            m_run = 0;
        end else if (lvl_above || !lvl_below) begin
            m_run = 0;
        end else begin
            if (m_run == 0) m_k = KMIN + KSTEP * (int'(dwell_code) - 1);
            m_run++;
            if (m_run == (1 << m_k)) begin
                m_gain = 0; m_run = 0;
            end
        end
        m_chg = (m_gain != prev) ? 1 : 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 model gain_reduce", int'(gain_reduce), m_gain);
            chk("R9 model gain_changed", int'(gain_changed), m_chg);
        end
    end

    task automatic cyc(input logic a, input logic b, input logic [2:0] c, input int n);
        for (int i = 0; i < n; i++) begin
            lvl_above  = a;
            lvl_below  = b;
            dwell_code = c;
            @(negedge clk);
        end
    endtask

    function automatic int dwell(input int code);
        return 1 << (KMIN + KSTEP * (code - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset gain_reduce", int'(gain_reduce), 0);
        chk("R1 reset gain_changed", int'(gain_changed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(gain_reduce), 0);

        // R11: below level in full gain does nothing.
        cyc(1'b0, 1'b1, 3'd1, 20);
        chk("R11 stays high gain", int'(gain_reduce), 0);
        chk("R11 no pulse", int'(gain_changed), 0);

        // R2: code zero ignores a strong level.
        cyc(1'b1, 1'b0, 3'd0, 10);
        chk("R2 off keeps high gain", int'(gain_reduce), 0);

        // R3 and R9: trip on one above sample.
        cyc(1'b1, 1'b0, 3'd1, 1);
        chk("R3 trip", int'(gain_reduce), 1);
        chk("R9 trip pulse", int'(gain_changed), 1);
        cyc(1'b0, 1'b0, 3'd1, 3);
        chk("R6 band holds low", int'(gain_reduce), 1);
        chk("R9 pulse one cycle", int'(gain_changed), 0);

        // R4: exact release edge for code 1.
        cyc(1'b0, 1'b1, 3'd1, dwell(1) - 1);
        chk("R4 still low one short", int'(gain_reduce), 1);
        cyc(1'b0, 1'b1, 3'd1, 1);
        chk("R4 release on last edge", int'(gain_reduce), 0);
        chk("R9 release pulse", int'(gain_changed), 1);

        // R5: above sample restarts the count.
        cyc(1'b1, 1'b0, 3'd1, 1);
        cyc(1'b0, 1'b1, 3'd1, 5);
        cyc(1'b1, 1'b0, 3'd1, 1);
        cyc(1'b0, 1'b1, 3'd1, dwell(1) - 1);
        chk("R5 restart after above", int'(gain_reduce), 1);
        cyc(1'b0, 1'b1, 3'd1, 1);
        chk("R5 release after full run", int'(gain_reduce), 0);

        // R6: in-band sample restarts the count.
        cyc(1'b1, 1'b0, 3'd1, 1);
        cyc(1'b0, 1'b1, 3'd1, 6);
        cyc(1'b0, 1'b0, 3'd1, 1);
        cyc(1'b0, 1'b1, 3'd1, dwell(1) - 1);
        chk("R6 restart after band", int'(gain_reduce), 1);
        cyc(1'b0, 1'b1, 3'd1, 1);
        chk("R6 release after full run", int'(gain_reduce), 0);

        // R10: release edge for every code.
        for (int c = 1; c <= 7; c++) begin
            cyc(1'b1, 1'b0, 3'(c), 1);
            cyc(1'b0, 1'b1, 3'(c), dwell(c) - 1);
            chk($sformatf("R10 code %0d one short", c), int'(gain_reduce), 1);
            cyc(1'b0, 1'b1, 3'(c), 1);
            chk($sformatf("R10 code %0d release", c), int'(gain_reduce), 0);
        end

        // R7: code change inside a run keeps the run's length.
        cyc(1'b1, 1'b0, 3'd1, 1);
        cyc(1'b0, 1'b1, 3'd1, 2);
        cyc(1'b0, 1'b1, 3'd7, dwell(1) - 3);
        chk("R7 latched K one short", int'(gain_reduce), 1);
        cyc(1'b0, 1'b1, 3'd7, 1);
        chk("R7 latched K release", int'(gain_reduce), 0);

        // R8: code zero while low releases at once.
        cyc(1'b1, 1'b0, 3'd2, 1);
        cyc(1'b1, 1'b0, 3'd2, 4);
        chk("R8 low before off", int'(gain_reduce), 1);
        cyc(1'b1, 1'b0, 3'd0, 1);
        chk("R8 off releases", int'(gain_reduce), 0);
        chk("R8 off pulse", int'(gain_changed), 1);
        cyc(1'b1, 1'b0, 3'd0, 5);
        chk("R2 off holds high", int'(gain_reduce), 0);

        // ASK-like pattern straddling thresholds never releases.
        cyc(1'b1, 1'b0, 3'd2, 1);
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b0, 3'd2, 3);
            cyc(1'b0, 1'b1, 3'd2, 3);
        end
        chk("R5 keyed data keeps low", int'(gain_reduce), 1);

        cyc(1'b0, 1'b0, 3'd0, 3);
        finish_run();
    end

endmodule